// File: doc/BRIEF.md
# Audio Serial Bit-Clock and Word-Select Generator

This block runs an audio serial output port as clock master. From a master audio clock it derives a bit clock, a word-select (left/right) signal, a one-cycle shift strobe marking where a downstream MSB-first serializer should present its next bit, and a frame-start marker that accompanies the strobe for the first bit of every frame.

The master-to-bit-clock ratio is programmed in one of two encodings. The first is a compact power-of-two code. The second is a linear ratio-minus-one value that reaches any ratio from 1 to 64. The frame length is a ratio-minus-one field as well, and the usual setting is 64 bit clocks per frame. Polarity options invert the bit clock and word-select independently. A separate format bit adds one more word-select inversion for I2S framing. A skew field moves the word-select edge ahead of the first data bit by 0 to 3 bit periods. The generator enable gates every counter, so the configuration can be changed safely while it is low. The hold input pauses the data stream but leaves the clocks and the configuration untouched.

Top module: `bclk_frame_gen`

## Requirements
- R1: While `gen_en` is low, the clock edge that follows drives `bclk`, `ws`, `shift_stb` and `frame_start` to 0 and clears every counter. In the first cycle after `gen_en` rises, the first bit of a frame starts.
- R2: With `div_sel_lin` = 0, the master-to-bit ratio N is 2 raised to the power `div_pow2` (1, 2, 4 or 8).
- R3: With `div_sel_lin` = 1, the ratio N is `div_lin_m1` + 1 (1 to 64).
- R4: Each bit period lasts N master cycles. The un-inverted bit clock is low for the first ceil(N/2) cycles and high for the remaining floor(N/2), so for odd N the high phase is one cycle shorter. At N = 1 the strobe fires every master cycle and the un-inverted bit clock stays low.
- R5: `shift_stb` is high for exactly the first master cycle of each bit period.
- R6: A frame holds `frame_len_m1` + 1 bit periods. `frame_start` is high together with the strobe of bit 0 only.
- R7: Before any inversion, word-select is 1 for bit positions p where (p + `ws_skew`) mod L < L/2, and 0 otherwise. L is the frame length, so the word-select edge leads the data by `ws_skew` bits.
- R8: `bclk_inv` inverts the running bit clock. Word-select is inverted by `ws_inv` XOR `fmt_i2s`.
- R9: While `hold` is high, `shift_stb` and `frame_start` stay low. The bit clock and word-select keep their normal waveforms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gen_en | input | 1 | Generator enable; low stops and clears everything |
| div_sel_lin | input | 1 | 1 selects the linear divider, 0 the power-of-two code |
| div_pow2 | input | 2 | log2 of the ratio (power-of-two encoding) |
| div_lin_m1 | input | 6 | Ratio minus one (linear encoding) |
| frame_len_m1 | input | 12 | Bits per frame minus one (63 for 64) |
| ws_skew | input | 2 | Word-select lead over data, in bit periods |
| bclk_inv | input | 1 | Invert the bit clock |
| ws_inv | input | 1 | Invert word-select |
| fmt_i2s | input | 1 | I2S framing: one extra word-select inversion |
| hold | input | 1 | Pause the strobes without stopping the clocks |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word-select |
| shift_stb | output | 1 | One-cycle strobe at the start of each bit |
| frame_start | output | 1 | Strobe of the first bit of a frame |

## Verification
The bench runs the generator with these ratios, each over at least one full frame:
- N = 1 through both encodings, which tells pass-through cadence apart from a real divide.
- Even power-of-two ratios 4 and 8, which tell the two encodings apart.
- Odd ratios 3 and 5, which expose the asymmetric high phase.
- N = 2 with a 16-bit frame, which separates the frame-length field from the fixed 64.

Skew values 0, 1 and 2 are combined with each inversion control and the I2S format bit, so a wrong word-select offset or polarity shows up as a shifted or flipped edge. A disable step between every pair of runs confirms the idle levels and the restart at bit 0. A run with hold asserted confirms that only the strobes disappear.

// File: rtl/bfg_pkg.sv
package bfg_pkg;
    localparam int CNT_W = 6;   // phase counter, ratios up to 64
    localparam int BIT_W = 12;  // bit-in-frame index, matches frame field

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] ph;
        logic [BIT_W-1:0] bit_idx;
    } seq_t;
endpackage

// File: rtl/bfg_ratio.sv
module bfg_ratio
    import bfg_pkg::*;
(
    input  logic             sel_lin,
    input  logic [1:0]       pow2,
    input  logic [CNT_W-1:0] lin_m1,
    output logic [CNT_W-1:0] ratio_m1,
    output logic [CNT_W:0]   low_len
);
    localparam int POW_N = 4;

    logic [CNT_W-1:0] pow_tab [POW_N];

    genvar gi;
    generate
        for (gi = 0; gi < POW_N; gi++) begin : g_pow
            assign pow_tab[gi] = CNT_W'((1 << gi) - 1);
        end
    endgenerate

    always_comb begin
        ratio_m1 = sel_lin ? lin_m1 : pow_tab[pow2];
        // ceil(N/2) = (ratio_m1 + 2) >> 1
        low_len  = ({1'b0, ratio_m1} + (CNT_W+1)'(2)) >> 1;
    end
endmodule

// File: rtl/bfg_seq.sv
module bfg_seq
    import bfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic [CNT_W-1:0] ratio_m1,
    input  logic [BIT_W-1:0] frame_m1,
    output seq_t             st
);
    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!gen_en) begin
            st_d = '0;
        end else if (!st_q.run) begin
            st_d.run = 1'b1;
        end else if (st_q.ph >= ratio_m1) begin
            st_d.ph      = '0;
            st_d.bit_idx = (st_q.bit_idx >= frame_m1) ? '0 : st_q.bit_idx + 1'b1;
        end else begin
            st_d.ph = st_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;

    // R4
    ph_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && st_q.run && st_q.ph == ratio_m1) |=> (st_q.ph == '0));

    // R1
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en && !st_q.run) |=> (st_q.run && st_q.ph == '0 && st_q.bit_idx == '0));
endmodule

// File: rtl/bfg_shape.sv
module bfg_shape
    import bfg_pkg::*;
(
    input  seq_t             st,
    input  logic [CNT_W:0]   low_len,
    input  logic [BIT_W-1:0] frame_m1,
    input  logic [1:0]       skew,
    input  logic             bclk_inv,
    input  logic             ws_inv,
    input  logic             fmt_i2s,
    input  logic             hold,
    output logic             bclk,
    output logic             ws,
    output logic             shift_stb,
    output logic             frame_start
);
    logic [BIT_W:0] len_w, half_w, pos_w;
    logic           bclk_raw, ws_raw;

    always_comb begin
        len_w  = {1'b0, frame_m1} + (BIT_W+1)'(1);
        half_w = len_w >> 1;
        pos_w  = {1'b0, st.bit_idx} + {{(BIT_W-1){1'b0}}, skew};
        if (pos_w >= len_w) pos_w = pos_w - len_w;
        bclk_raw    = ({1'b0, st.ph} >= low_len);
        ws_raw      = (pos_w < half_w);
        bclk        = st.run & (bclk_raw ^ bclk_inv);
        ws          = st.run & (ws_raw ^ ws_inv ^ fmt_i2s);
        shift_stb   = st.run & (st.ph == '0) & ~hold;
        frame_start = shift_stb & (st.bit_idx == '0);
    end
endmodule

// File: rtl/bclk_frame_gen.sv
module bclk_frame_gen
    import bfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        gen_en,
    input  logic        div_sel_lin,
    input  logic [1:0]  div_pow2,
    input  logic [5:0]  div_lin_m1,
    input  logic [11:0] frame_len_m1,
    input  logic [1:0]  ws_skew,
    input  logic        bclk_inv,
    input  logic        ws_inv,
    input  logic        fmt_i2s,
    input  logic        hold,
    output logic        bclk,
    output logic        ws,
    output logic        shift_stb,
    output logic        frame_start
);
    logic [CNT_W-1:0] ratio_m1;
    logic [CNT_W:0]   low_len;
    seq_t             st;

    bfg_ratio u_ratio (
        .sel_lin  (div_sel_lin),
        .pow2     (div_pow2),
        .lin_m1   (div_lin_m1),
        .ratio_m1 (ratio_m1),
        .low_len  (low_len)
    );

    bfg_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .gen_en   (gen_en),
        .ratio_m1 (ratio_m1),
        .frame_m1 (frame_len_m1),
        .st       (st)
    );

    bfg_shape u_shape (
        .st          (st),
        .low_len     (low_len),
        .frame_m1    (frame_len_m1),
        .skew        (ws_skew),
        .bclk_inv    (bclk_inv),
        .ws_inv      (ws_inv),
        .fmt_i2s     (fmt_i2s),
        .hold        (hold),
        .bclk        (bclk),
        .ws          (ws),
        .shift_stb   (shift_stb),
        .frame_start (frame_start)
    );

    // R1
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> (!bclk && !ws && !shift_stb && !frame_start));

    // R9
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (!shift_stb && !frame_start));

    // R6
    fs_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> shift_stb);

    // R5
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_stb && gen_en && ratio_m1 != '0 && $stable(ratio_m1)) |=> !shift_stb);
endmodule

// File: tb/bclk_frame_gen_bench.sv
module bclk_frame_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_en = 1'b0;
    logic        div_sel_lin = 1'b0;
    logic [1:0]  div_pow2 = '0;
    logic [5:0]  div_lin_m1 = '0;
    logic [11:0] frame_len_m1 = 12'd63;
    logic [1:0]  ws_skew = '0;
    logic        bclk_inv = 1'b0;
    logic        ws_inv = 1'b0;
    logic        fmt_i2s = 1'b0;
    logic        hold = 1'b0;
    logic        bclk, ws, shift_stb, frame_start;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;  // 50 MHz

    bclk_frame_gen u_bclk_frame_gen (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .div_sel_lin(div_sel_lin),
        .div_pow2(div_pow2), .div_lin_m1(div_lin_m1), .frame_len_m1(frame_len_m1),
        .ws_skew(ws_skew), .bclk_inv(bclk_inv), .ws_inv(ws_inv), .fmt_i2s(fmt_i2s),
        .hold(hold), .bclk(bclk), .ws(ws), .shift_stb(shift_stb),
        .frame_start(frame_start)
    );

    // Monitor: pop one expected vector per falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [3:0] e;
            string      tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            n_checks++;
            if ({bclk, ws, shift_stb, frame_start} !== e) begin
                n_fail++;
                $display("FAIL %s: {bclk,ws,stb,fs} got %b exp %b at %0t",
                         tg, {bclk, ws, shift_stb, frame_start}, e, $time);
            end
        end
    end

    function automatic logic [3:0] model(int t, int n, int len, int sk,
                                         bit bi, bit wi, bit f, bit h);
        int ph, b, pos;
        bit bc, w, st, fs;
        ph  = t % n;
        b   = (t / n) % len;
        bc  = (ph >= (n + 1) / 2) ^ bi;
        pos = (b + sk) % len;
        w   = (pos < len / 2) ^ wi ^ f;
        st  = (ph == 0) && !h;
        fs  = st && (b == 0);
        return {bc, w, st, fs};
    endfunction

    // Driver: configure, enable, push expected per cycle, then disable
    task automatic run_case(string tg, bit lin, int p2, int lm1, int fm1, int sk,
                            bit bi, bit wi, bit f, bit h, int cycles);
        int n;
        n = lin ? lm1 + 1 : (1 << p2);
        @(negedge clk);
        div_sel_lin  = lin;
        div_pow2     = 2'(p2);
        div_lin_m1   = 6'(lm1);
        frame_len_m1 = 12'(fm1);
        ws_skew      = 2'(sk);
        bclk_inv     = bi;
        ws_inv       = wi;
        fmt_i2s      = f;
        hold         = h;
        gen_en       = 1'b1;
        for (int t = 0; t < cycles; t++) begin
            @(posedge clk);
            #1;
            exp_q.push_back(model(t, n, fm1 + 1, sk, bi, wi, f, h));
            tag_q.push_back(tg);
        end
        @(negedge clk);
        gen_en = 1'b0;
        @(posedge clk);
        #1;
        exp_q.push_back(4'b0000);   // R1: idle levels after disable
        tag_q.push_back("R1 disable");
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;   // R1 reset state
        if ({bclk, ws, shift_stb, frame_start} !== 4'b0000) begin
            n_fail++;
            $display("FAIL R1 reset: got %b exp 0000", {bclk, ws, shift_stb, frame_start});
        end
        rst_n = 1'b1;
        // R3 R4: linear ratio 1, strobe every cycle
        run_case("R3 R4 ratio1",      1, 0, 0, 63, 0, 0, 0, 0, 0, 200);
        // R2 R5 R7: power-of-two ratio 4, left-justified skew 0
        run_case("R2 R5 R7 pow4",     0, 2, 0, 63, 0, 0, 0, 0, 0, 64*4 + 20);
        // R2 R7 R8: ratio 8, I2S framing skew 1
        run_case("R2 R7 R8 pow8 i2s", 0, 3, 0, 63, 1, 0, 0, 1, 0, 64*8 + 40);
        // R3 R4 R8: odd ratio 5 with inverted bit clock
        run_case("R3 R4 R8 odd5",     1, 0, 4, 63, 0, 1, 0, 0, 0, 64*5 + 30);
        // R6 R7 R8: ratio 2, 16-bit frame, skew 2, inverted word-select
        run_case("R6 R7 R8 len16",    1, 0, 1, 15, 2, 0, 1, 0, 0, 16*2*3 + 5);
        // R9: hold with odd ratio 3, clocks keep running
        run_case("R9 hold",           1, 0, 2, 63, 1, 0, 0, 1, 1, 64*3 + 20);
        // R2 R8: power-of-two ratio 1, all inversions plus I2S
        run_case("R2 R8 pow1 inv",    0, 0, 0, 63, 1, 1, 1, 1, 0, 130);
        // R6: restart after a short run lands on frame start again
        run_case("R6 restart",        1, 0, 2, 63, 0, 0, 0, 0, 0, 10);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule